// File: doc/BRIEF.md
# SDRAM Full-Page Write Sequencer

This block drives the command, address and data pins of a two-bank SDRAM so that one open row receives a full-page write burst. A full-page burst has no natural end: once the device's column pointer passes the last column of the page it wraps back to column zero and keeps storing. The sequencer therefore always ends the burst itself. There are two ways to end it. The first is a burst-stop command, which leaves the row open so that a later burst to the same row can start straight away at a new column. The second is an early precharge, which closes the row. Each way has its own data-latency rule, and the sequencer meets both by raising DQM on the cycles whose data must not land.

A client raises `start` with a bank, a row and a starting column while `can_start` is high. After that it supplies one word per cycle on `wr_data`, and a word is taken in every cycle where `wr_ready` is high. When `wr_valid` is low in such a cycle, the column still advances but nothing is stored there. To end the burst the client pulses `term_req`, using `term_pre` to choose precharge (1) or burst stop (0). With a row left open by a stop, a `term_req` pulse closes the row. A `start` to a different bank or row precharges the open row first and then activates the new one. All pin outputs are registered.

Top module: `sdram_fp_writer`

## Requirements
- R1: In reset and after it, the pins carry NOP ({cs_n,ras_n,cas_n,we_n} = 0111), `sd_dq_oe` is low, `sd_dqm` is high and `can_start` is high.
- R2: A start from idle issues activate (0011) with the bank on `sd_ba` and the row on `sd_addr`. A write command (0100) follows exactly T_RCD cycles later and carries the column on `sd_addr`, and `sd_addr[10]` is low on every write command.
- R3: Each word taken in a `wr_ready` cycle appears on `sd_dq` with `sd_dq_oe` high in the next cycle, one word per cycle and in order. `sd_dqm` equals the inverse of `wr_valid`. The stream continues past the end of the page with no new write command, so the device's column wraps.
- R4: A `term_req` with `term_pre`=0 during a burst issues burst stop (0110) in the next cycle, with `sd_dqm` high and DQ undriven. No word is taken in the `term_req` cycle, so the last stored word is the one before the stop.
- R5: A `term_req` with `term_pre`=1 during a burst gives T_RDL-1 NOP cycles and then a single-bank precharge (0010, `sd_addr[10]` low). `sd_dqm` is high on each of these cycles, so the precharge comes at least T_RDL cycles after the last stored word.
- R6: No activate appears earlier than T_RP cycles after a precharge, and `can_start` is low in that window.
- R7: After a burst stop the row stays open, and a start to the same bank and row issues a write in the next cycle without an activate.
- R8: A start to another bank or row while a row is open precharges the open bank, then activates the new row and writes to it.
- R9: A `term_req` pulse while a row is open and `can_start` is high issues a precharge to that bank.
- R10: `wr_ready` is high only in cycles whose word is driven out next cycle, and never during activate wait, masking or precharge recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst (taken while `can_start` is high) |
| start_bank | input | 1 | Target bank |
| start_row | input | ROW_W | Target row |
| start_col | input | COL_W | First column of the burst |
| wr_data | input | DQ_W | Write word |
| wr_valid | input | 1 | Word is to be stored (low masks it) |
| term_req | input | 1 | End the burst, or close an open row |
| term_pre | input | 1 | 1 = end by precharge, 0 = end by burst stop |
| can_start | output | 1 | A start is accepted this cycle |
| wr_ready | output | 1 | The word on `wr_data` is taken this cycle |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 1 | Bank select |
| sd_addr | output | ADDR_W | Row or column address; bit 10 is the auto-precharge flag |
| sd_dq | output | DQ_W | Write data |
| sd_dq_oe | output | 1 | Drive enable for `sd_dq` |
| sd_dqm | output | 1 | Data mask |

## Verification
Most internal faults show up at the pins within one or two cycles. A wrong counter load moves the write command or the precharge relative to its activate or last data word, and a wrong mask lets the word of the stop or precharge cycle reach the memory. A lost open-row record shows up as an extra or a missing activate on the next start. Other faults only show up once a burst is over, such as a word taken in the terminating cycle or a miscounted position in the stream. A behavioural device in the bench catches those by comparing its stored page contents, including wrapped overwrites, with a shadow page built from the words the bench handed over.

// File: rtl/sdram_fp_writer.sv
module sdram_fp_writer #(
  parameter int DQ_W   = 16,
  parameter int ADDR_W = 11,
  parameter int ROW_W  = 11,
  parameter int COL_W  = 8,
  parameter int T_RCD  = 2,
  parameter int T_RDL  = 2,
  parameter int T_RP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_bank,
  input  logic [ROW_W-1:0]  start_row,
  input  logic [COL_W-1:0]  start_col,
  input  logic [DQ_W-1:0]   wr_data,
  input  logic              wr_valid,
  input  logic              term_req,
  input  logic              term_pre,
  output logic              can_start,
  output logic              wr_ready,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [DQ_W-1:0]   sd_dq,
  output logic              sd_dq_oe,
  output logic              sd_dqm
);

  localparam int TMAX  = (T_RCD > T_RDL) ? ((T_RCD > T_RP) ? T_RCD : T_RP)
                                         : ((T_RDL > T_RP) ? T_RDL : T_RP);
  localparam int CNT_W = $clog2(TMAX + 1) + 1;
  localparam int AP    = 10;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_BST = 4'b0110;
  localparam logic [3:0] C_PRE = 4'b0010;

  localparam logic [CNT_W-1:0] LD_RCD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] LD_RDL = CNT_W'(T_RDL - 1);
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);

  typedef enum logic [2:0] {S_IDLE, S_RCD, S_BURST, S_MASK, S_RP, S_OPEN} st_t;

  st_t              state;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       cmd;
  logic             open_bank, pend, pend_bank;
  logic [ROW_W-1:0] open_row, pend_row;
  logic [COL_W-1:0] cur_col, pend_col;

  wire gate_ok = (cnt <= CNT_W'(1));
  wire hit     = start && (start_bank == open_bank) && (start_row == open_row);

  assign can_start = (state == S_IDLE && !pend) || (state == S_OPEN && gate_ok);
  assign wr_ready  = (state == S_RCD && cnt == '0) ||
                     (state == S_BURST && !term_req) ||
                     (state == S_OPEN && gate_ok && !term_req && hit);

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      cmd       <= C_NOP;
      sd_ba     <= 1'b0;
      sd_addr   <= '0;
      sd_dq     <= '0;
      sd_dq_oe  <= 1'b0;
      sd_dqm    <= 1'b1;
      open_bank <= 1'b0;
      open_row  <= '0;
      cur_col   <= '0;
      pend      <= 1'b0;
      pend_bank <= 1'b0;
      pend_row  <= '0;
      pend_col  <= '0;
    end else begin
      cmd      <= C_NOP;
      sd_dq_oe <= 1'b0;
      sd_dqm   <= 1'b1;
      case (state)
        S_IDLE: begin
          if (pend || start) begin
            cmd       <= C_ACT;
            sd_ba     <= pend ? pend_bank : start_bank;
            sd_addr   <= ADDR_W'(pend ? pend_row : start_row);
            open_bank <= pend ? pend_bank : start_bank;
            open_row  <= pend ? pend_row : start_row;
            cur_col   <= pend ? pend_col : start_col;
            pend      <= 1'b0;
            cnt       <= LD_RCD;
            state     <= S_RCD;
          end
        end
        S_RCD: begin
          if (cnt == '0) begin
            cmd      <= C_WR;
            sd_ba    <= open_bank;
            sd_addr  <= ADDR_W'(cur_col);
            sd_dq    <= wr_data;
            sd_dq_oe <= 1'b1;
            sd_dqm   <= !wr_valid;
            state    <= S_BURST;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_BURST: begin
          if (term_req) begin
            if (!term_pre) begin
              cmd   <= C_BST;
              cnt   <= LD_RDL;
              state <= S_OPEN;
            end else if (T_RDL > 1) begin
              cnt   <= LD_RDL;
              state <= S_MASK;
            end else begin
              cmd     <= C_PRE;
              sd_ba   <= open_bank;
              sd_addr <= '0;
              cnt     <= LD_RP;
              state   <= S_RP;
            end
          end else begin
            sd_dq    <= wr_data;
            sd_dq_oe <= 1'b1;
            sd_dqm   <= !wr_valid;
          end
        end
        S_MASK: begin
          if (gate_ok) begin
            cmd     <= C_PRE;
            sd_ba   <= open_bank;
            sd_addr <= '0;
            cnt     <= LD_RP;
            state   <= S_RP;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_RP: begin
          if (gate_ok) state <= S_IDLE;
          else         cnt   <= cnt - 1'b1;
        end
        S_OPEN: begin
          if (!gate_ok) begin
            cnt <= cnt - 1'b1;
          end else if (term_req || (start && !hit)) begin
            cmd       <= C_PRE;
            sd_ba     <= open_bank;
            sd_addr   <= '0;
            cnt       <= LD_RP;
            state     <= S_RP;
            pend      <= !term_req;
            pend_bank <= start_bank;
            pend_row  <= start_row;
            pend_col  <= start_col;
          end else if (hit) begin
            cmd      <= C_WR;
            sd_ba    <= open_bank;
            sd_addr  <= ADDR_W'(start_col);
            sd_dq    <= wr_data;
            sd_dq_oe <= 1'b1;
            sd_dqm   <= !wr_valid;
            state    <= S_BURST;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [CNT_W-1:0] since_act, since_data, since_pre;
  localparam logic [CNT_W-1:0] SAT = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act  <= SAT;
      since_data <= SAT;
      since_pre  <= SAT;
    end else begin
      since_act  <= (cmd == C_ACT) ? CNT_W'(1) : (since_act == SAT ? SAT : since_act + 1'b1);
      since_data <= (sd_dq_oe && !sd_dqm) ? CNT_W'(1) : (since_data == SAT ? SAT : since_data + 1'b1);
      since_pre  <= (cmd == C_PRE) ? CNT_W'(1) : (since_pre == SAT ? SAT : since_pre + 1'b1);
    end
  end

  p_no_autopre_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_WR) |-> !sd_addr[AP]);
  p_act_to_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_WR && since_act != SAT) |-> since_act >= CNT_W'(T_RCD));
  p_oe_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> (cmd == C_WR || cmd == C_NOP));
  p_stop_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_BST) |-> (sd_dqm && !sd_dq_oe));
  p_pre_recovery_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_PRE) |-> (sd_dqm && !sd_addr[AP] && since_data >= CNT_W'(T_RDL)));
  p_pre_to_act_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_ACT) |-> since_pre >= CNT_W'(T_RP));
  p_ready_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |=> sd_dq_oe);

endmodule

// File: tb/sdram_fp_writer_bench.sv
`timescale 1ns/1ps
module sdram_fp_writer_bench;
  localparam int DQ_W = 16, ADDR_W = 11, ROW_W = 11, COL_W = 4;
  localparam int T_RCD = 2, T_RDL = 2, T_RP = 2;
  localparam int PAGE = 1 << COL_W;

  logic clk = 0, rst_n = 0;
  logic start = 0, start_bank = 0, wr_valid = 0, term_req = 0, term_pre = 0;
  logic [ROW_W-1:0] start_row = '0;
  logic [COL_W-1:0] start_col = '0;
  logic [DQ_W-1:0] wr_data = '0;
  logic can_start, wr_ready, cs_n, ras_n, cas_n, we_n, ba, dq_oe, dqm;
  logic [ADDR_W-1:0] addr;
  logic [DQ_W-1:0] dq;

  always #4 clk = ~clk;

  sdram_fp_writer #(.DQ_W(DQ_W), .ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .T_RCD(T_RCD), .T_RDL(T_RDL), .T_RP(T_RP)) u_sdram_fp_writer (
    .clk(clk), .rst_n(rst_n), .start(start), .start_bank(start_bank),
    .start_row(start_row), .start_col(start_col), .wr_data(wr_data),
    .wr_valid(wr_valid), .term_req(term_req), .term_pre(term_pre),
    .can_start(can_start), .wr_ready(wr_ready), .sd_cs_n(cs_n), .sd_ras_n(ras_n),
    .sd_cas_n(cas_n), .sd_we_n(we_n), .sd_ba(ba), .sd_addr(addr), .sd_dq(dq),
    .sd_dq_oe(dq_oe), .sd_dqm(dqm));

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural device
  logic [DQ_W-1:0] mem [2][PAGE];
  logic [DQ_W-1:0] shadow [2][PAGE];
  bit open_b [2];
  int cyc = 0, last_act = -100, last_pre = -100, last_store = -100;
  int act_cnt = 0, pre_cnt = 0;
  bit fresh = 0, burst = 0, bba = 0;
  int bcol = 0;
  wire [3:0] pins = {cs_n, ras_n, cas_n, we_n};

  always @(posedge clk) begin
    if (rst_n) begin
      cyc++;
      case (pins)
        4'b0011: begin
          chk(cyc - last_pre >= T_RP, "R6", "activate after precharge gap", cyc - last_pre, T_RP);
          chk(!open_b[ba], "R8", "activate to closed bank", int'(open_b[ba]), 0);
          open_b[ba] = 1; act_cnt++; last_act = cyc; fresh = 1;
        end
        4'b0100: begin
          chk(!addr[10], "R2", "A10 on write", int'(addr[10]), 0);
          chk(open_b[ba], "R2", "write to open bank", int'(open_b[ba]), 1);
          if (fresh) chk(cyc - last_act == T_RCD, "R2", "activate to write", cyc - last_act, T_RCD);
          fresh = 0; burst = 1; bba = ba; bcol = int'(addr[COL_W-1:0]);
          if (dq_oe && !dqm) begin mem[bba][bcol] = dq; last_store = cyc; end
        end
        4'b0110: begin
          chk(dqm == 1'b1, "R4", "DQM on burst stop", int'(dqm), 1);
          burst = 0;
        end
        4'b0010: begin
          chk(dqm == 1'b1, "R5", "DQM on precharge", int'(dqm), 1);
          chk(cyc - last_store >= T_RDL, "R5", "last data to precharge", cyc - last_store, T_RDL);
          burst = 0; open_b[ba] = 0; pre_cnt++; last_pre = cyc;
        end
        default: begin
          if (burst) begin
            bcol = (bcol + 1) % PAGE;
            if (dq_oe && !dqm) begin mem[bba][bcol] = dq; last_store = cyc; end
          end
        end
      endcase
    end
  end

  task automatic wait_can();
    forever begin
      @(negedge clk); #1;
      if (can_start) break;
    end
  endtask

  // one burst: the first loop cycle raises start (can_start known high)
  task automatic burst_run(input bit b, input int row, input int col, input int n, input bit pre);
    int k = 0;
    bit first = 1;
    int guard = 0;
    wait_can();
    forever begin
      start = first; start_bank = b; start_row = ROW_W'(row); start_col = COL_W'(col);
      if (k < n) begin
        wr_data = DQ_W'($urandom); wr_valid = ($urandom % 4) != 0; term_req = 0;
        #1;
        if (wr_ready) begin
          if (wr_valid) shadow[b][(col + k) % PAGE] = wr_data;
          k++;
        end else if (!first) begin
          chk(k == 0, "R10", "ready dropped mid-burst", k, 0);
        end
      end else begin
        term_req = 1; term_pre = pre; wr_valid = 1; wr_data = '1;
        #1;
        chk(!wr_ready, "R4", "no word taken with terminate", int'(wr_ready), 0);
      end
      @(posedge clk);
      first = 0;
      @(negedge clk);
      start = 0;
      if (term_req) begin term_req = 0; break; end
      guard++;
      if (guard > 400) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic close_row();
    wait_can();
    term_req = 1;
    @(posedge clk); @(negedge clk);
    term_req = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0;
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < PAGE; c++)
        if (mem[b][c] !== shadow[b][c]) bad++;
    chk(bad == 0, req, "mismatching page words", bad, 0);
  endtask

  initial begin
    #(8 * 150000);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int a0, p0;
    bit is_open = 0;
    bit ob = 0;
    int orow = 0;
    void'($urandom(32'd2024));
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < PAGE; c++) begin mem[b][c] = '0; shadow[b][c] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pins == 4'b0111, "R1", "pins in reset", int'(pins), 7);
    chk(!dq_oe && dqm, "R1", "oe/dqm in reset", int'({dq_oe, dqm}), 1);
    rst_n = 1;
    @(negedge clk); #1;
    chk(pins == 4'b0111 && can_start, "R1", "idle after reset", int'({pins, can_start}), 15);

    // R2 R3 R4: fresh burst, stop
    burst_run(0, 5, 3, 6, 0);
    cmp_mem("R4");
    // R7 hit restart, wraps past page end (R3)
    a0 = act_cnt;
    burst_run(0, 5, 12, 9, 0);
    chk(act_cnt == a0, "R7", "activates on open-row restart", act_cnt - a0, 0);
    cmp_mem("R3");
    // R8 miss restart, long wrap, end by precharge (R5)
    a0 = act_cnt; p0 = pre_cnt;
    burst_run(0, 9, 0, 2 * PAGE + 3, 1);
    chk(act_cnt == a0 + 1 && pre_cnt == p0 + 2, "R8", "precharge+activate count",
        (act_cnt - a0) * 10 + pre_cnt - p0, 12);
    cmp_mem("R5");
    #1 chk(can_start && pins == 4'b0111, "R6", "idle after precharge recovery", int'(can_start), 1);
    // R9 close after stop, single-word burst at last column
    burst_run(1, 2, PAGE - 1, 1, 0);
    p0 = pre_cnt;
    close_row();
    chk(pre_cnt == p0 + 1 && !open_b[1], "R9", "close open row", pre_cnt - p0, 1);
    cmp_mem("R10");

    // random mix
    for (int i = 0; i < 24; i++) begin
      bit b = 1'($urandom);
      int row = int'($urandom % 3);
      int col = int'($urandom % PAGE);
      int n = 1 + int'($urandom % (PAGE + 9));
      bit pre = 1'($urandom);
      if (is_open && ($urandom % 3) == 0) begin close_row(); is_open = 0; end
      if (is_open && ($urandom % 2) == 0) begin b = ob; row = orow; end
      a0 = act_cnt;
      burst_run(b, row, col, n, pre);
      if (is_open && b == ob && row == orow)
        chk(act_cnt == a0, "R7", "random hit restart", act_cnt - a0, 0);
      else
        chk(act_cnt == a0 + 1, "R8", "random activate", act_cnt - a0, 1);
      is_open = !pre; ob = b; orow = row;
      cmp_mem("R3");
    end
    if (is_open) close_row();
    chk(!open_b[0] && !open_b[1], "R9", "all banks closed", int'({open_b[1], open_b[0]}), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule